// File: doc/BRIEF.md
# Dual-Output Converter Read Controller

This block sits on the host side of a serial link to a converter that has two sampling channels and two serial data outputs. On a command it pulls chip select low and drives a serial clock. The serial clock is derived from the system clock by a divider chosen per command. The block shifts in the bits that the converter places on its data lines. Depending on the command, a frame reads both result words in parallel (14 or 16 clocks), reads both words one after another from one chosen line (32 clocks), or is a short frame that tells the converter to drop into its low-power state.

Each received 16-bit slot holds, in this order: a leading zero, a channel identifier bit, twelve data bits sent MSB first and, for frames longer than 14 clocks, two trailing zeros. The controller checks the framing bits and reports each channel's 12-bit word with an error flag. It then holds chip select high for a programmed quiet time before it accepts the next command.

Top module: `dualconv_rd_ctrl`

## Requirements
- R1: During and after synchronous reset, cs_n and sclk are 1, and busy and res_valid are 0.
- R2: Call the latched half_period H, with 0 treated as 1. With cs_n low, sclk starts high and toggles every H system clocks, so the first falling edge comes H cycles after cs_n falls. While cs_n is high, sclk stays high.
- R3: cmd_mode encoding: 1 means a 14-clock read, 2 a 16-clock read, 3 a 32-clock read. A read frame ends with cs_n rising on the same system edge as the rising sclk edge that follows the last falling edge.
- R4: cmd_mode 0 is a power-down frame. cs_n rises with the rising sclk edge after the 5th falling edge. No res_valid is produced, and res_a, res_b, err_a and err_b keep their values.
- R5: Data is sampled at the rising sclk edge. Within a slot the first bit is the leading zero and the second is the identifier. The next twelve bits are data, MSB first.
- R6: In 14- and 16-clock reads, sdata_a and sdata_b are captured in parallel. res_a comes from sdata_a with expected identifier 0. res_b comes from sdata_b with expected identifier 1.
- R7: In a 32-clock read, only the line chosen by cmd_line is used (0 selects sdata_a, 1 selects sdata_b). Its first 16-bit slot belongs to that line's own channel and its second slot to the other channel. The unselected line has no effect.
- R8: A channel's error flag is set if its leading bit is 1 or its identifier differs from the expected value. In 16- and 32-clock reads it is also set if either trailing bit is 1.
- R9: res_valid is a one-cycle pulse in the cycle after cs_n rises at the end of a read. Results change only at that pulse.
- R10: busy rises the cycle after a command is accepted and stays high through one finish cycle plus quiet_cycles+1 cycles after cs_n rises. cmd_valid is accepted only when busy is 0 and is ignored otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, taken when busy is low |
| cmd_mode | input | 2 | 0 power-down, 1 read-14, 2 read-16, 3 read-32 |
| cmd_line | input | 1 | Line used in 32-clock reads (0 = A, 1 = B) |
| half_period | input | DIV_W | System clocks per sclk half period (0 acts as 1) |
| quiet_cycles | input | QUIET_W | Quiet time setting after a frame |
| sdata_a | input | 1 | Serial data from converter output A |
| sdata_b | input | 1 | Serial data from converter output B |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles high |
| busy | output | 1 | Frame or quiet interval in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_a | output | 12 | Channel A data word |
| res_b | output | 12 | Channel B data word |
| err_a | output | 1 | Channel A framing error |
| err_b | output | 1 | Channel B framing error |

## Verification
The assertions check on every cycle that sclk idles high whenever chip select is released, and that chip select is low only while busy. They also check that the result strobe is a lone pulse with chip select high, that no power-down frame yields a strobe, that the bit count never passes the frame length, and that chip select never falls again before the previous quiet setting has elapsed. Only the bench scenarios can show exact edge positions for each divider, the routing of slots to channels in each mode, the error cases, and that results survive a power-down frame unchanged.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int DATA_W  = 12;
  localparam int SLOT_W  = DATA_W + 4;
  localparam int SHIFT_W = 2 * SLOT_W;
  localparam int LANES   = 2;
  localparam int PD_LEN  = 5;

  typedef enum logic [1:0] {
    MODE_PD  = 2'd0,
    MODE_R14 = 2'd1,
    MODE_R16 = 2'd2,
    MODE_R32 = 2'd3
  } rd_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_FIN   = 2'd2,
    ST_QUIET = 2'd3
  } ctl_st_e;

  function automatic int frame_len(rd_mode_e m);
    case (m)
      MODE_R14: return SLOT_W - 2;
      MODE_R16: return SLOT_W;
      MODE_R32: return SHIFT_W;
      default:  return PD_LEN;
    endcase
  endfunction
endpackage

// File: rtl/dcr_sclk_gen.sv
module dcr_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             sclk,
  output logic             fall_tick,
  output logic             rise_tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;
  logic             wrap;

  assign lim       = (half == '0) ? '0 : half - 1'b1;
  assign wrap      = run && (cnt == lim);
  assign fall_tick = wrap && sclk;
  assign rise_tick = wrap && !sclk;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      sclk <= 1'b1;
    end else if (wrap) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

  // R2: the divider count never passes the half-period limit
  assert_div_bound_R2: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= lim));
endmodule

// File: rtl/dcr_lane_cap.sv
module dcr_lane_cap import dcr_pkg::*; (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            clr,
  input  logic                            shift_en,
  input  logic [LANES-1:0]                din,
  output logic [LANES-1:0][SHIFT_W-1:0]   sh
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SHIFT_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst || clr)    q <= '0;
      else if (shift_en) q <= {q[SHIFT_W-2:0], din[l]};
    end
    assign sh[l] = q;
  end
endmodule

// File: rtl/dcr_slot_check.sv
module dcr_slot_check import dcr_pkg::*; #(
  parameter int EXP_ID = 0
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic              chk_trail,
  output logic [DATA_W-1:0] data,
  output logic              err
);
  logic lead_bad, id_bad, trail_bad;

  assign lead_bad  = slot[SLOT_W-1];
  assign id_bad    = slot[SLOT_W-2] != 1'(EXP_ID);
  assign trail_bad = chk_trail && (slot[1:0] != 2'b00);
  assign data      = slot[SLOT_W-3:2];
  assign err       = lead_bad || id_bad || trail_bad;
endmodule

// File: rtl/dualconv_rd_ctrl.sv
module dualconv_rd_ctrl import dcr_pkg::*; #(
  parameter int DIV_W   = 8,
  parameter int QUIET_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_mode,
  input  logic               cmd_line,
  input  logic [DIV_W-1:0]   half_period,
  input  logic [QUIET_W-1:0] quiet_cycles,
  input  logic               sdata_a,
  input  logic               sdata_b,
  output logic               cs_n,
  output logic               sclk,
  output logic               busy,
  output logic               res_valid,
  output logic [DATA_W-1:0]  res_a,
  output logic [DATA_W-1:0]  res_b,
  output logic               err_a,
  output logic               err_b
);
  localparam int CNT_W = $clog2(SHIFT_W + 1);

  ctl_st_e            st, st_nxt;
  rd_mode_e           mode_l;
  logic               line_l;
  logic [DIV_W-1:0]   half_l;
  logic [QUIET_W-1:0] quiet_l, qcnt, q_end;
  logic [CNT_W-1:0]   rs_cnt, len;
  logic               run, fall_tick, rise_tick, last_bit, accept;
  logic               cs_n_q, busy_q, res_valid_q;
  logic [DATA_W-1:0]  res_a_q, res_b_q;
  logic               err_a_q, err_b_q;

  logic [LANES-1:0][SHIFT_W-1:0] sh;
  logic [LANES-1:0][SLOT_W-1:0]  slot;
  logic [LANES-1:0][DATA_W-1:0]  dec_data;
  logic [LANES-1:0]              dec_err;
  logic [SHIFT_W-1:0]            sel_sh;
  logic                          chk_trail;

  assign run      = (st == ST_XFER);
  assign accept   = (st == ST_IDLE) && cmd_valid;
  assign len      = CNT_W'(frame_len(mode_l));
  assign last_bit = rise_tick && (rs_cnt == len - 1'b1);

  dcr_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
    .clk(clk), .rst(rst), .run(run), .half(half_l),
    .sclk(sclk), .fall_tick(fall_tick), .rise_tick(rise_tick)
  );

  dcr_lane_cap u_cap (
    .clk(clk), .rst(rst), .clr(accept), .shift_en(rise_tick),
    .din({sdata_b, sdata_a}), .sh(sh)
  );

  // slot routing per read mode
  always_comb begin
    sel_sh    = line_l ? sh[1] : sh[0];
    slot[0]   = {sh[0][SLOT_W-3:0], 2'b00};
    slot[1]   = {sh[1][SLOT_W-3:0], 2'b00};
    chk_trail = 1'b0;
    case (mode_l)
      MODE_R16: begin
        slot[0]   = sh[0][SLOT_W-1:0];
        slot[1]   = sh[1][SLOT_W-1:0];
        chk_trail = 1'b1;
      end
      MODE_R32: begin
        chk_trail = 1'b1;
        if (line_l) begin
          slot[1] = sel_sh[SHIFT_W-1:SLOT_W];
          slot[0] = sel_sh[SLOT_W-1:0];
        end else begin
          slot[0] = sel_sh[SHIFT_W-1:SLOT_W];
          slot[1] = sel_sh[SLOT_W-1:0];
        end
      end
      default: ;
    endcase
  end

  for (genvar c = 0; c < LANES; c++) begin : g_chk
    dcr_slot_check #(.EXP_ID(c)) u_chk (
      .slot(slot[c]), .chk_trail(chk_trail),
      .data(dec_data[c]), .err(dec_err[c])
    );
  end

  always_comb begin
    st_nxt = st;
    case (st)
      ST_IDLE:  if (cmd_valid) st_nxt = ST_XFER;
      ST_XFER:  if (last_bit) st_nxt = ST_FIN;
      ST_FIN:   st_nxt = ST_QUIET;
      ST_QUIET: if (qcnt == quiet_l) st_nxt = ST_IDLE;
      default:  st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      cs_n_q      <= 1'b1;
      busy_q      <= 1'b0;
      res_valid_q <= 1'b0;
      res_a_q     <= '0;
      res_b_q     <= '0;
      err_a_q     <= 1'b0;
      err_b_q     <= 1'b0;
      mode_l      <= MODE_PD;
      line_l      <= 1'b0;
      half_l      <= '0;
      quiet_l     <= '0;
      qcnt        <= '0;
      q_end       <= '0;
      rs_cnt      <= '0;
    end else begin
      st          <= st_nxt;
      busy_q      <= (st_nxt != ST_IDLE);
      res_valid_q <= 1'b0;
      case (st)
        ST_IDLE: if (cmd_valid) begin
          mode_l  <= rd_mode_e'(cmd_mode);
          line_l  <= cmd_line;
          half_l  <= half_period;
          quiet_l <= quiet_cycles;
          rs_cnt  <= '0;
          cs_n_q  <= 1'b0;
        end
        ST_XFER: begin
          if (rise_tick) rs_cnt <= rs_cnt + 1'b1;
          if (last_bit)  cs_n_q <= 1'b1;
        end
        ST_FIN: begin
          qcnt  <= '0;
          q_end <= quiet_l;
          if (mode_l != MODE_PD) begin
            res_valid_q <= 1'b1;
            res_a_q     <= dec_data[0];
            res_b_q     <= dec_data[1];
            err_a_q     <= dec_err[0];
            err_b_q     <= dec_err[1];
          end
        end
        default: qcnt <= qcnt + 1'b1;
      endcase
    end
  end

  assign cs_n      = cs_n_q;
  assign busy      = busy_q;
  assign res_valid = res_valid_q;
  assign res_a     = res_a_q;
  assign res_b     = res_b_q;
  assign err_a     = err_a_q;
  assign err_b     = err_b_q;

  // gap tracker for the quiet-interval check
  logic [QUIET_W+1:0] gap_cnt;
  logic               seen_frame;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt    <= '0;
      seen_frame <= 1'b0;
    end else begin
      if (!cs_n_q)              gap_cnt <= '0;
      else if (gap_cnt != '1)   gap_cnt <= gap_cnt + 1'b1;
      if (!cs_n_q) seen_frame <= 1'b1;
    end
  end

  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (rst)
    cs_n_q |-> sclk);
  assert_frame_len_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_XFER) |-> (rs_cnt < len));
  assert_pd_no_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FIN && mode_l == MODE_PD) |=> !res_valid_q);
  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (rst)
    res_valid_q |=> !res_valid_q);
  assert_strobe_deselected_R9: assert property (@(posedge clk) disable iff (rst)
    res_valid_q |-> (cs_n_q && busy_q));
  assert_busy_in_frame_R10: assert property (@(posedge clk) disable iff (rst)
    !cs_n_q |-> busy_q);
  assert_quiet_gap_R10: assert property (@(posedge clk) disable iff (rst)
    (seen_frame && $fell(cs_n_q)) |-> ({2'b00, q_end} < gap_cnt));
endmodule

// File: tb/sim_dualconv_rd_ctrl.sv
module sim_dualconv_rd_ctrl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, cmd_valid, cmd_line, sdata_a, sdata_b;
  logic [1:0]  cmd_mode;
  logic [7:0]  half_period, quiet_cycles;
  logic        cs_n, sclk, busy, res_valid, err_a, err_b;
  logic [11:0] res_a, res_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  dualconv_rd_ctrl u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .cmd_line(cmd_line), .half_period(half_period), .quiet_cycles(quiet_cycles),
    .sdata_a(sdata_a), .sdata_b(sdata_b), .cs_n(cs_n), .sclk(sclk),
    .busy(busy), .res_valid(res_valid), .res_a(res_a), .res_b(res_b),
    .err_a(err_a), .err_b(err_b)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // 16-bit slot as sent on the wire; index 0 is the first bit
  function automatic logic [15:0] fr(input bit lead, input bit id,
                                     input logic [11:0] d, input logic [1:0] t);
    logic [15:0] f;
    f[0] = lead;
    f[1] = id;
    for (int i = 0; i < 12; i++) f[2+i] = d[11-i];
    f[14] = t[1];
    f[15] = t[0];
    return f;
  endfunction

  // expected {err, data} for a slot starting at bit s
  function automatic logic [12:0] expect_word(input logic [31:0] b, input int s,
                                              input bit id, input bit trail);
    logic [11:0] d;
    bit e;
    for (int i = 0; i < 12; i++) d[11-i] = b[s+2+i];
    e = (b[s] != 1'b0) || (b[s+1] != id) || (trail && (b[s+14] || b[s+15]));
    return {e, d};
  endfunction

  task automatic run_frame(input int mode, input bit line, input int h, input int q,
                           input logic [31:0] ba, input logic [31:0] bb,
                           input bit spam, input string req);
    int n, he, t_end, fc;
    int bad_cs, bad_sc, bad_busy, bad_v;
    bit ps, e_cs, e_sc, e_busy, e_v;
    logic [11:0] pa, pb;
    logic pea, peb;
    logic [12:0] xa, xb, first, second;
    logic [31:0] src;
    n  = (mode == 0) ? 5 : (mode == 1) ? 14 : (mode == 2) ? 16 : 32;
    he = (h == 0) ? 1 : h;
    t_end = 2 * n * he;
    bad_cs = 0; bad_sc = 0; bad_busy = 0; bad_v = 0;
    pa = res_a; pb = res_b; pea = err_a; peb = err_b;
    chk(busy == 1'b0, "R10", "busy before command", int'(busy), 0);
    cmd_mode = 2'(mode); cmd_line = line;
    half_period = 8'(h); quiet_cycles = 8'(q);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    fc = 0; ps = 1'b1;
    for (int j = 0; j <= t_end + 2 + q; j++) begin
      e_cs   = (j >= t_end);
      e_sc   = (j >= t_end) ? 1'b1 : (((j / he) % 2) == 0);
      e_busy = (j <= t_end + 1 + q);
      e_v    = (j == t_end + 1) && (mode != 0);
      if (cs_n !== e_cs)        bad_cs++;
      if (sclk !== e_sc)        bad_sc++;
      if (busy !== e_busy)      bad_busy++;
      if (res_valid !== e_v)    bad_v++;
      if (ps && !sclk && !cs_n) begin
        fc++;
        sdata_a = ba[fc-1];
        sdata_b = bb[fc-1];
      end
      ps = sclk;
      if (spam) begin
        cmd_valid = (j >= 3 && j <= 6);
        cmd_mode  = 2'd0;
      end
      if (j < t_end + 2 + q) @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk(bad_cs == 0, (mode == 0) ? "R4" : "R3", "cs_n cycles off", bad_cs, 0);
    chk(bad_sc == 0, "R2", "sclk cycles off", bad_sc, 0);
    chk(bad_busy == 0, "R10", "busy cycles off", bad_busy, 0);
    chk(bad_v == 0, "R9", "res_valid cycles off", bad_v, 0);
    if (mode == 0) begin
      chk(res_a == pa && err_a == pea, "R4", "res_a kept", int'(res_a), int'(pa));
      chk(res_b == pb && err_b == peb, "R4", "res_b kept", int'(res_b), int'(pb));
    end else begin
      if (mode == 3) begin
        src    = line ? bb : ba;
        first  = expect_word(src, 0, line, 1'b1);
        second = expect_word(src, 16, !line, 1'b1);
        xa = line ? second : first;
        xb = line ? first : second;
      end else begin
        xa = expect_word(ba, 0, 1'b0, mode == 2);
        xb = expect_word(bb, 0, 1'b1, mode == 2);
      end
      chk(res_a == xa[11:0], req, "res_a", int'(res_a), int'(xa[11:0]));
      chk(res_b == xb[11:0], req, "res_b", int'(res_b), int'(xb[11:0]));
      chk(err_a == xa[12], req, "err_a", int'(err_a), int'(xa[12]));
      chk(err_b == xb[12], req, "err_b", int'(err_b), int'(xb[12]));
    end
  endtask

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; cmd_mode = 2'd0; cmd_line = 1'b0;
    half_period = 8'd1; quiet_cycles = 8'd0; sdata_a = 1'b0; sdata_b = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b1, "R1", "cs_n/sclk in reset",
        int'({cs_n, sclk}), 3);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b1, "R1", "cs_n/sclk after reset",
        int'({cs_n, sclk}), 3);
    chk(busy == 1'b0 && res_valid == 1'b0, "R1", "busy/res_valid after reset",
        int'({busy, res_valid}), 0);
    // R6 R5 R10: 16-clock read, divider 2, command held while busy
    run_frame(2, 1'b0, 2, 3, {16'h0, fr(0, 0, 12'hA5C, 2'b00)},
              {16'h0, fr(0, 1, 12'h3F1, 2'b00)}, 1'b1, "R6");
    // R6: 14-clock read, fastest divider, no quiet
    run_frame(1, 1'b0, 1, 0, {16'hFFFF, fr(0, 0, 12'h001, 2'b11)},
              {16'hFFFF, fr(0, 1, 12'hFFF, 2'b11)}, 1'b0, "R6");
    // R8: trailing bit set on A, leading bit set on B
    run_frame(2, 1'b0, 1, 1, {16'h0, fr(0, 0, 12'h123, 2'b01)},
              {16'h0, fr(1, 1, 12'h456, 2'b00)}, 1'b0, "R8");
    // R8: wrong identifier on A in a 14-clock read
    run_frame(1, 1'b0, 3, 2, {16'h0, fr(0, 1, 12'h7E7, 2'b00)},
              {16'h0, fr(0, 1, 12'h818, 2'b00)}, 1'b0, "R8");
    // R4: power-down frame leaves results untouched
    run_frame(0, 1'b0, 3, 5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R4");
    // R7: 32-clock read on line A, line B carries noise
    run_frame(3, 1'b0, 1, 2, {fr(0, 1, 12'hBEE, 2'b00), fr(0, 0, 12'h0C3, 2'b00)},
              32'hDEAD_BEEF, 1'b0, "R7");
    // R7: 32-clock read on line B, B slot first
    run_frame(3, 1'b1, 2, 0, 32'h1234_5678,
              {fr(0, 0, 12'h5A5, 2'b00), fr(0, 1, 12'hC0F, 2'b00)}, 1'b0, "R7");
    // R8: 32-clock read with wrong identifier in second slot
    run_frame(3, 1'b0, 1, 1, {fr(0, 0, 12'h222, 2'b00), fr(0, 0, 12'h111, 2'b00)},
              32'h0, 1'b0, "R8");
    // R2: half_period 0 behaves as 1
    run_frame(2, 1'b0, 0, 0, {16'h0, fr(0, 0, 12'h9C3, 2'b00)},
              {16'h0, fr(0, 1, 12'h3C9, 2'b00)}, 1'b0, "R2");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule